// File: doc/BRIEF.md
# Serial Flash Command Acceptance Front End

This block sits on the slave side of a single-bit serial NOR flash interface and decides, for each chip-select frame, whether the command it carried may run. The serial clock, select and data inputs are brought into the system clock domain by synchronizers. The bits are then assembled into an opcode byte, up to three address bytes and a count of trailing data bytes. When select is released, the block checks the frame's length rules, the write-enable latch, the busy state and the block-protect range. It then either emits a one-cycle execute strobe or drops the frame silently.

A small status register holds the write-enable latch, a busy flag and four block-protect bits. The busy flag is raised by every accepted program, erase or status write. It is lowered by a completion pulse from the array controller behind this block, so the controller decides how long each internal cycle lasts. The array itself, read data return and the multi-line I/O data paths are handled elsewhere; this block only validates and forwards.

Top module: `spi_cmd_front`

## Requirements
- R1: Bits are taken most significant first on each rising serial clock while select is low; the first byte is the opcode and the next three bytes form the 24-bit address, high byte first.
- R2: The status port reads bit 0 busy, bit 1 write-enable latch, bits 5:2 protect bits BP3..BP0, bits 7:6 zero; after reset it reads 00h.
- R3: Opcode 06h sets the write-enable latch and 04h clears it, each only when the frame ends on a byte boundary; a frame ending mid-byte changes nothing.
- R4: An accepted command gives a single-cycle execute strobe carrying the opcode, the address (zero for opcodes without an address) and a length: bytes after the address for addressed opcodes (zero if fewer than four bytes), else bytes after the opcode.
- R5: Page program 02h is accepted only with byte-aligned framing and at least five bytes in total; shorter or mid-byte frames are ignored and leave the write-enable latch set.
- R6: Sector erase 20h and block erase D8h are accepted only when exactly 32 bits were clocked.
- R7: Chip erase C7h is accepted only when BP2..BP0 are all zero.
- R8: Status write 01h needs byte-aligned framing and at least two bytes; bits 5:2 of the first byte after the opcode become BP3..BP0.
- R9: An accepted 01h, 02h, 20h, D8h or C7h clears the write-enable latch and sets busy; busy stays set until a completion pulse arrives.
- R10: While busy, every frame except status read 05h is ignored and the status register is left unchanged.
- R11: With n = BP2..BP0, n = 0 protects nothing and n = 7 protects everything; for n = 1..6, BP3 = 0 protects 64 KB blocks 0 to 255-2^(n-1) and BP3 = 1 protects blocks 2^(n-1) to 255. A program or sector/block erase whose start address is in a protected block is ignored.
- R12: Read opcodes 03h, 0Bh, 3Bh, BBh, EBh and status read 05h are accepted at any frame length of eight bits or more, without the write-enable latch; unknown opcodes and frames shorter than eight bits are ignored.
- R13: Program, erase and status write are ignored when the write-enable latch is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| op_done | input | 1 | Completion pulse from the array controller, clears busy |
| exec_valid | output | 1 | One-cycle execute strobe |
| exec_opcode | output | 8 | Opcode of the accepted command |
| exec_addr | output | 24 | Address of the accepted command |
| exec_len | output | 10 | Data byte count of the accepted command |
| status | output | 8 | Status register |

## Verification
Frames are driven at exact, one-short, one-long and mid-byte lengths for each write-type opcode. This separates the exact-length rule for erases from the minimum-length rule for program and the any-length rule for reads. Protect settings in both directions are paired with addresses just inside and just outside the protected range, so an off-by-one in the range decode shows up as a missing or extra strobe. Frames sent while busy, and with the latch clear, show that acceptance is gated by status and not only by framing.

// File: rtl/spi_front_pkg.sv
package spi_front_pkg;

  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_PP    = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_FREAD = 8'h0B;
  localparam logic [7:0] OP_SE    = 8'h20;
  localparam logic [7:0] OP_DOUT  = 8'h3B;
  localparam logic [7:0] OP_DIO   = 8'hBB;
  localparam logic [7:0] OP_CE    = 8'hC7;
  localparam logic [7:0] OP_BE    = 8'hD8;
  localparam logic [7:0] OP_QIO   = 8'hEB;

  typedef enum logic [2:0] {
    K_NONE,
    K_READ,
    K_RSTAT,
    K_LATCH,
    K_WSTAT,
    K_PROG,
    K_ERASE,
    K_CHIP
  } cmd_kind_e;

  function automatic cmd_kind_e classify(input logic [7:0] op);
    cmd_kind_e k;
    case (op)
      OP_READ, OP_FREAD, OP_DOUT, OP_DIO, OP_QIO: k = K_READ;
      OP_RDSR:                                    k = K_RSTAT;
      OP_WREN, OP_WRDI:                           k = K_LATCH;
      OP_WRSR:                                    k = K_WSTAT;
      OP_PP:                                      k = K_PROG;
      OP_SE, OP_BE:                               k = K_ERASE;
      OP_CE:                                      k = K_CHIP;
      default:                                    k = K_NONE;
    endcase
    return k;
  endfunction

  function automatic logic is_write_op(input logic [7:0] op);
    return (op == OP_WRSR) || (op == OP_PP) || (op == OP_SE) ||
           (op == OP_BE) || (op == OP_CE);
  endfunction

endpackage

// File: rtl/spi_bit_sync.sv
module spi_bit_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_deser.sv
module spi_deser #(
  parameter int CNT_W  = 13,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_rise,
  input  logic              cs_fall,
  input  logic              cs_low,
  input  logic              mosi,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic [7:0]        opcode,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]        first_dat
);
  localparam int LEN_W = CNT_W - 3;
  localparam int AB    = ADDR_W / 8;

  logic [6:0]       sh;
  logic [7:0]       nb;
  logic [CNT_W-1:0] nxt;
  logic [LEN_W-1:0] idx;
  logic             sat, take, byte_done;

  assign nb        = {sh, mosi};
  assign sat       = &bit_cnt;
  assign nxt       = bit_cnt + CNT_W'(1);
  assign idx       = nxt[CNT_W-1:3];
  assign take      = sck_rise && cs_low && !cs_fall;
  assign byte_done = (nxt[2:0] == 3'd0) && !sat;

  always_ff @(posedge clk) begin
    if (rst || cs_fall) begin
      bit_cnt   <= '0;
      sh        <= '0;
      opcode    <= '0;
      addr      <= '0;
      first_dat <= '0;
    end else if (take) begin
      sh <= nb[6:0];
      if (!sat) bit_cnt <= nxt;
      if (byte_done) begin
        if (idx == LEN_W'(1)) opcode <= nb;
        if (idx >= LEN_W'(2) && idx <= LEN_W'(AB + 1))
          addr <= {addr[ADDR_W-9:0], nb};
        if (idx == LEN_W'(2)) first_dat <= nb;
      end
    end
  end

  // R1
  bitcnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (take && !sat) |=> (bit_cnt == $past(bit_cnt) + CNT_W'(1)));

  // R1
  bitcnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    cs_fall |=> (bit_cnt == '0));
endmodule

// File: rtl/blk_protect.sv
module blk_protect #(
  parameter int BLK_W = 8
) (
  input  logic [3:0]       bp,
  input  logic [BLK_W-1:0] blk,
  output logic             hit
);
  localparam int NBLK = 1 << BLK_W;

  logic [2:0]     n;
  logic [BLK_W:0] span, lower_lim, blk_x;

  assign n         = bp[2:0];
  assign span      = (BLK_W+1)'(1) << (n - 3'd1);
  assign lower_lim = (BLK_W+1)'(NBLK) - span;
  assign blk_x     = {1'b0, blk};

  always_comb begin
    if (n == 3'd0)      hit = 1'b0;
    else if (n == 3'd7) hit = 1'b1;
    else if (!bp[3])    hit = (blk_x < lower_lim);
    else                hit = (blk_x >= span);
  end
endmodule

// File: rtl/cmd_accept.sv
module cmd_accept
  import spi_front_pkg::*;
#(
  parameter int CNT_W  = 13,
  parameter int ADDR_W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cs_rise,
  input  logic [CNT_W-1:0]    bit_cnt,
  input  logic [7:0]          opcode,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [7:0]          first_dat,
  input  logic                prot_hit,
  input  logic                op_done,
  output logic                exec_valid,
  output logic [7:0]          exec_opcode,
  output logic [ADDR_W-1:0]   exec_addr,
  output logic [CNT_W-4:0]    exec_len,
  output logic                wel,
  output logic                busy,
  output logic [3:0]          bp
);
  localparam int LEN_W = CNT_W - 3;
  localparam int AB    = ADDR_W / 8;

  cmd_kind_e        kind;
  logic             opc_ok, aligned, has_addr, wr_kind;
  logic             accept, set_wel, clr_wel, start_busy, load_bp;
  logic [LEN_W-1:0] nbytes, len_c;
  logic             unused_bits;

  assign unused_bits = ^{first_dat[7:6], first_dat[1:0]};

  assign kind     = classify(opcode);
  assign opc_ok   = bit_cnt >= CNT_W'(8);
  assign aligned  = opc_ok && (bit_cnt[2:0] == 3'd0);
  assign nbytes   = bit_cnt[CNT_W-1:3];
  assign has_addr = (kind == K_READ) || (kind == K_PROG) || (kind == K_ERASE);
  assign wr_kind  = (kind == K_WSTAT) || (kind == K_PROG) ||
                    (kind == K_ERASE) || (kind == K_CHIP);

  always_comb begin
    accept  = 1'b0;
    set_wel = 1'b0;
    case (kind)
      K_RSTAT: accept = opc_ok;
      K_READ:  accept = opc_ok && !busy;
      K_LATCH: set_wel = aligned && !busy && (opcode == OP_WREN);
      K_WSTAT: accept = aligned && (nbytes >= LEN_W'(2)) && wel && !busy;
      K_PROG:  accept = aligned && (nbytes >= LEN_W'(AB + 2)) && wel &&
                        !busy && !prot_hit;
      K_ERASE: accept = (bit_cnt == CNT_W'(8 * (AB + 1))) && wel &&
                        !busy && !prot_hit;
      K_CHIP:  accept = aligned && wel && !busy && (bp[2:0] == 3'd0);
      default: accept = 1'b0;
    endcase
    accept     = accept && cs_rise;
    set_wel    = set_wel && cs_rise;
    start_busy = accept && wr_kind;
    load_bp    = accept && (kind == K_WSTAT);
    clr_wel    = start_busy ||
                 (cs_rise && (opcode == OP_WRDI) && aligned && !busy);
  end

  always_comb begin
    if (has_addr)
      len_c = (nbytes >= LEN_W'(AB + 1)) ? nbytes - LEN_W'(AB + 1) : '0;
    else
      len_c = (nbytes >= LEN_W'(1)) ? nbytes - LEN_W'(1) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      exec_valid  <= 1'b0;
      exec_opcode <= '0;
      exec_addr   <= '0;
      exec_len    <= '0;
      wel         <= 1'b0;
      busy        <= 1'b0;
      bp          <= '0;
    end else begin
      exec_valid <= accept;
      if (accept) begin
        exec_opcode <= opcode;
        exec_addr   <= has_addr ? addr : '0;
        exec_len    <= len_c;
      end
      if (clr_wel)      wel <= 1'b0;
      else if (set_wel) wel <= 1'b1;
      if (start_busy)   busy <= 1'b1;
      else if (op_done) busy <= 1'b0;
      if (load_bp)      bp <= first_dat[5:2];
    end
  end

  // R4
  exec_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    exec_valid |=> !exec_valid);

  // R9
  write_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (exec_valid && is_write_op(exec_opcode)) |-> (busy && !wel));

  // R13
  write_wel_chk: assert property (@(posedge clk) disable iff (rst)
    (exec_valid && is_write_op(exec_opcode)) |-> $past(wel));

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !op_done) |=> busy);

  // R11
  prot_block_chk: assert property (@(posedge clk) disable iff (rst)
    (exec_valid && (exec_opcode == OP_PP || exec_opcode == OP_SE ||
                    exec_opcode == OP_BE)) |-> !$past(prot_hit));

  // R6
  erase_len_chk: assert property (@(posedge clk) disable iff (rst)
    (exec_valid && (exec_opcode == OP_SE || exec_opcode == OP_BE)) |->
      ($past(bit_cnt) == CNT_W'(8 * (AB + 1))));
endmodule

// File: rtl/spi_cmd_front.sv
module spi_cmd_front #(
  parameter int CNT_W       = 13,
  parameter int ADDR_W      = 24,
  parameter int BLK_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                spi_sck,
  input  logic                spi_cs_n,
  input  logic                spi_mosi,
  input  logic                op_done,
  output logic                exec_valid,
  output logic [7:0]          exec_opcode,
  output logic [ADDR_W-1:0]   exec_addr,
  output logic [CNT_W-4:0]    exec_len,
  output logic [7:0]          status
);
  logic sck_s, cs_s, mosi_s, sck_q, cs_q;
  logic sck_rise, cs_fall, cs_rise;

  spi_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck (
    .clk(clk), .rst(rst), .d(spi_sck), .q(sck_s));
  spi_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst(rst), .d(spi_cs_n), .q(cs_s));
  spi_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
    .clk(clk), .rst(rst), .d(spi_mosi), .q(mosi_s));

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_s;
    end
  end

  assign sck_rise = sck_s && !sck_q;
  assign cs_fall  = !cs_s && cs_q;
  assign cs_rise  = cs_s && !cs_q;

  logic [CNT_W-1:0]  bit_cnt;
  logic [7:0]        opcode, first_dat;
  logic [ADDR_W-1:0] addr;
  logic              prot_hit, wel, busy;
  logic [3:0]        bp;

  spi_deser #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_deser (
    .clk(clk), .rst(rst), .sck_rise(sck_rise), .cs_fall(cs_fall),
    .cs_low(!cs_s), .mosi(mosi_s), .bit_cnt(bit_cnt), .opcode(opcode),
    .addr(addr), .first_dat(first_dat));

  blk_protect #(.BLK_W(BLK_W)) u_prot (
    .bp(bp), .blk(addr[ADDR_W-1 -: BLK_W]), .hit(prot_hit));

  cmd_accept #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_accept (
    .clk(clk), .rst(rst), .cs_rise(cs_rise), .bit_cnt(bit_cnt),
    .opcode(opcode), .addr(addr), .first_dat(first_dat),
    .prot_hit(prot_hit), .op_done(op_done), .exec_valid(exec_valid),
    .exec_opcode(exec_opcode), .exec_addr(exec_addr), .exec_len(exec_len),
    .wel(wel), .busy(busy), .bp(bp));

  assign status = {2'b00, bp, wel, busy};

  // R2
  status_top_chk: assert property (@(posedge clk) disable iff (rst)
    status[7:6] == 2'b00);
endmodule

// File: tb/test_spi_cmd_front.sv
module test_spi_cmd_front;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0, op_done = 1'b0;
  logic        exec_valid;
  logic [7:0]  exec_opcode;
  logic [23:0] exec_addr;
  logic [9:0]  exec_len;
  logic [7:0]  status;

  int vectors = 0;
  int fails   = 0;

  typedef struct {
    logic [7:0]  op;
    logic [23:0] a;
    logic [9:0]  l;
    string       req;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  spi_cmd_front i_spi_cmd_front (
    .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .op_done(op_done), .exec_valid(exec_valid),
    .exec_opcode(exec_opcode), .exec_addr(exec_addr), .exec_len(exec_len),
    .status(status));

  // monitor: pops and compares every strobe
  always @(negedge clk) begin
    if (!rst && exec_valid) begin
      vectors++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R4 unexpected strobe: got op=%h addr=%h len=%0d, expected none",
                 exec_opcode, exec_addr, exec_len);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (exec_opcode !== e.op || exec_addr !== e.a || exec_len !== e.l) begin
          fails++;
          $display("FAIL %s strobe: got op=%h addr=%h len=%0d, expected op=%h addr=%h len=%0d",
                   e.req, exec_opcode, exec_addr, exec_len, e.op, e.a, e.l);
        end
      end
    end
  end

  task automatic expect_exec(input logic [7:0] op, input logic [23:0] a,
                             input logic [9:0] l, input string req);
    exp_t e;
    e.op = op; e.a = a; e.l = l; e.req = req;
    exp_q.push_back(e);
  endtask

  // sends the first nbits of data, most significant bit first
  task automatic xfer(input logic [63:0] data, input int nbits);
    @(negedge clk) spi_cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = data[63-i];
      repeat (4) @(negedge clk);
      spi_sck = 1'b1;
      repeat (4) @(negedge clk);
      spi_sck = 1'b0;
    end
    repeat (4) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (12) @(negedge clk);
    if (exp_q.size() != 0) begin
      vectors++;
      fails++;
      $display("FAIL %s missing strobe: got none, expected op=%h",
               exp_q[0].req, exp_q[0].op);
      exp_q.delete();
    end
  endtask

  task automatic chk_status(input logic [7:0] exp, input string req);
    @(negedge clk);
    vectors++;
    if (status !== exp) begin
      fails++;
      $display("FAIL %s status: got %h, expected %h", req, status, exp);
    end
  endtask

  task automatic done_pulse;
    @(negedge clk) op_done = 1'b1;
    @(negedge clk) op_done = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_all;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk_status(8'h00, "R2");                                  // R2 reset value

    xfer({8'h02, 24'h001000, 8'h11, 24'h0}, 40);               // R13 no latch
    chk_status(8'h00, "R13");

    xfer({8'h06, 56'h0}, 9);                                   // R3 mid-byte
    chk_status(8'h00, "R3");
    xfer({8'h06, 56'h0}, 8);
    chk_status(8'h02, "R3");
    xfer({8'h04, 56'h0}, 8);
    chk_status(8'h00, "R3");
    xfer({8'h06, 56'h0}, 8);

    expect_exec(8'h02, 24'h012345, 10'd2, "R5");               // R5 R9 program
    xfer({8'h02, 24'h012345, 8'hAA, 8'h55, 16'h0}, 48);
    chk_status(8'h01, "R9");

    xfer({8'h06, 56'h0}, 8);                                   // R10 busy
    chk_status(8'h01, "R10");
    xfer({8'h03, 24'h000100, 32'h0}, 32);
    expect_exec(8'h05, 24'h0, 10'd0, "R10");
    xfer({8'h05, 56'h0}, 8);
    done_pulse();
    chk_status(8'h00, "R9");

    xfer({8'h06, 56'h0}, 8);                                   // R5 short frames
    xfer({8'h02, 24'h000200, 32'h0}, 32);
    chk_status(8'h02, "R5");
    xfer({8'h02, 24'h000200, 8'h33, 24'h0}, 43);
    chk_status(8'h02, "R5");

    xfer({8'h20, 24'h7F1000, 32'h0}, 31);                      // R6 lengths
    xfer({8'h20, 24'h7F1000, 8'h00, 24'h0}, 40);
    chk_status(8'h02, "R6");
    expect_exec(8'h20, 24'h7F1000, 10'd0, "R1");               // R1 R6 address
    xfer({8'h20, 24'h7F1000, 32'h0}, 32);
    chk_status(8'h01, "R6");
    done_pulse();

    xfer({8'h06, 56'h0}, 8);
    expect_exec(8'hD8, 24'h3A0000, 10'd0, "R6");
    xfer({8'hD8, 24'h3A0000, 32'h0}, 32);
    done_pulse();

    xfer({8'h06, 56'h0}, 8);                                   // R8 bp=3 lower
    expect_exec(8'h01, 24'h0, 10'd1, "R8");
    xfer({8'h01, 8'h0C, 48'h0}, 16);
    chk_status(8'h0D, "R8");
    done_pulse();
    chk_status(8'h0C, "R8");

    xfer({8'h06, 56'h0}, 8);                                   // R11 edge 251/252
    xfer({8'h20, 24'hFB0000, 32'h0}, 32);
    chk_status(8'h0E, "R11");
    expect_exec(8'h20, 24'hFC0000, 10'd0, "R11");
    xfer({8'h20, 24'hFC0000, 32'h0}, 32);
    done_pulse();

    xfer({8'h06, 56'h0}, 8);                                   // R7 chip erase
    xfer({8'hC7, 56'h0}, 8);
    chk_status(8'h0E, "R7");

    expect_exec(8'h01, 24'h0, 10'd1, "R8");                    // bp=0xB upper
    xfer({8'h01, 8'h2C, 48'h0}, 16);
    done_pulse();
    chk_status(8'h2C, "R8");
    xfer({8'h06, 56'h0}, 8);
    expect_exec(8'h20, 24'h030000, 10'd0, "R11");
    xfer({8'h20, 24'h030000, 32'h0}, 32);
    done_pulse();
    xfer({8'h06, 56'h0}, 8);
    xfer({8'h20, 24'h040000, 32'h0}, 32);
    chk_status(8'h2E, "R11");

    expect_exec(8'h01, 24'h0, 10'd1, "R8");                    // bp=7 all
    xfer({8'h01, 8'h1C, 48'h0}, 16);
    done_pulse();
    xfer({8'h06, 56'h0}, 8);
    xfer({8'h02, 24'h000000, 8'h01, 24'h0}, 40);
    chk_status(8'h1E, "R11");
    expect_exec(8'h01, 24'h0, 10'd1, "R8");
    xfer({8'h01, 8'h00, 48'h0}, 16);
    done_pulse();
    xfer({8'h06, 56'h0}, 8);
    expect_exec(8'hC7, 24'h0, 10'd0, "R7");
    xfer({8'hC7, 56'h0}, 8);
    chk_status(8'h01, "R7");
    done_pulse();

    expect_exec(8'h0B, 24'h123456, 10'd1, "R12");              // R12 reads
    xfer({8'h0B, 24'h123456, 8'h77, 24'h0}, 43);
    expect_exec(8'h3B, 24'h0, 10'd0, "R12");
    xfer({8'h3B, 8'hFF, 48'h0}, 12);
    expect_exec(8'hEB, 24'hABCDEF, 10'd0, "R12");
    xfer({8'hEB, 24'hABCDEF, 32'h0}, 32);
    expect_exec(8'hBB, 24'h00F0F0, 10'd0, "R12");
    xfer({8'hBB, 24'h00F0F0, 32'h0}, 32);
    xfer({8'h9F, 56'h0}, 8);                                   // unknown
    xfer({8'h03, 56'h0}, 5);                                   // short
    chk_status(8'h00, "R12");
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    disable fork;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R4 pending: got %0d unmatched, expected 0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule